// File: doc/BRIEF.md
# Fault Timer and Protection Supervisor

This block sits beside the bridge controller of a lamp inverter and decides when a protection event should warn the outside world and when it should halt the controller. It gathers five internally detected fault flags (over-voltage, over-current, arcing, ignition failure, hard switching) and one external fault request. Whenever any of these is active, it counts cycles of the fault timing oscillator. The oscillator is modelled as a single-cycle tick input, one tick for each full charge/discharge period.

After the first counted period, the block pulls its active-low fault status line low. After the fifteenth period it enters a halted state that stays latched until the enable input is taken low. Internal faults immediately withdraw permission for PWM dimming and frequency synchronisation. A fault that only comes in from outside leaves both permissions in place. The external request is taken in only while the lamp-current loop reports closed. Its captured value is frozen while the block itself holds the status line low. Start-up out of reset waits as long as the timing pin is flagged as shorted to ground.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst_i` is high or `en_i` is low, `flt_n_o` is 1, and `halt_o`, `run_o`, `dim_ok_o` and `sync_ok_o` are all 0.
- R2: After reset, `run_o` rises on the first clock edge at which `en_i` is high and `tpin_gnd_i` is low. Until then, ticks are not counted, even when a fault is present.
- R3: While any internal fault flag is 1, `dim_ok_o` and `sync_ok_o` are 0 in the same cycle. With no internal fault present, both equal `run_o`.
- R4: A fault present only through the external request leaves `dim_ok_o` and `sync_ok_o` at 1 while the timer counts.
- R5: The external request is captured on a clock edge only when `loop_ok_i` is 1. The captured value acts as a fault from the following cycle onward.
- R6: While running with a fault present, each cycle with `tick_i` high advances a 4-bit period counter. Ticks with no fault present do not advance it.
- R7: `flt_n_o` goes to 0 on the clock edge that completes the first counted period.
- R8: The clock edge that completes the fifteenth counted period sets `halt_o` to 1 and clears `run_o`. `halt_o` stays 1 after the faults clear, and `flt_n_o` stays 0.
- R9: If all faults clear before the fifteenth period, the counter returns to zero and `flt_n_o` is 1 after the next edge. A later fault then needs a full fifteen periods to halt.
- R10: While `flt_n_o` is 0, changes on the external request are not captured.
- R11: Taking `en_i` low for one edge clears the counter and the halt latch. Raising it again restarts the block from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; low clears all state |
| ovp_i | input | 1 | Over-voltage flag |
| ocp_i | input | 1 | Over-current flag |
| arc_i | input | 1 | Arcing flag |
| ign_fail_i | input | 1 | Ignition failure flag |
| hsw_i | input | 1 | Hard-switching flag |
| ext_req_i | input | 1 | External fault request |
| loop_ok_i | input | 1 | Lamp-current loop closed |
| tick_i | input | 1 | One timing-oscillator period completed |
| tpin_gnd_i | input | 1 | Timing pin shorted to ground |
| flt_n_o | output | 1 | Active-low fault status |
| halt_o | output | 1 | Latched halt state |
| run_o | output | 1 | Controller allowed to operate |
| dim_ok_o | output | 1 | PWM dimming permitted |
| sync_ok_o | output | 1 | Frequency synchronisation permitted |

## Verification
The hardest situation to reach is an external request that changes at the very edge where the block's own warning is still active. The capture must be blocked at that edge and then allowed one edge later, after the count has collapsed. The stimulus gets there by raising an internal fault and delivering one tick so that the status line falls. In a single cycle it then drops the internal fault and raises the external request with the loop closed, and checks that the status line is released before the request is taken in. A second hard case is the halt that follows a purely external fault. Here the captured request must stay frozen through fourteen further ticks, even though the external input is removed while the status line is low.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HALT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic ovp;
        logic ocp;
        logic arc;
        logic ign;
        logic hsw;
    } int_flags_t;

    typedef struct packed {
        logic int_any;
        logic ext_held;
        logic any;
    } fault_view_t;

    function automatic logic any_internal(input int_flags_t f);
        return f.ovp | f.ocp | f.arc | f.ign | f.hsw;
    endfunction

endpackage

// File: rtl/fsup_fault_merge.sv
module fsup_fault_merge
    import fsup_pkg::*;
(
    input  logic        clk_i,
    input  logic        clr_i,
    input  int_flags_t  flags_i,
    input  logic        ext_req_i,
    input  logic        loop_ok_i,
    input  logic        status_low_i,
    output fault_view_t view_o
);

    logic ext_q;
    logic ext_capture;
    logic int_any;

    assign int_any     = any_internal(flags_i);
    assign ext_capture = loop_ok_i & ~status_low_i;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            ext_q <= 1'b0;
        end else if (ext_capture) begin
            ext_q <= ext_req_i;
        end
    end

    always_comb begin
        view_o.int_any  = int_any;
        view_o.ext_held = ext_q;
        view_o.any      = int_any | ext_q;
    end

endmodule

// File: rtl/fsup_cycle_timer.sv
module fsup_cycle_timer #(
    parameter int CNT_W       = 4,
    parameter int WARN_CYCLES = 1,
    parameter int HALT_CYCLES = 15
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             count_en_i,
    input  logic             fault_i,
    input  logic             tick_i,
    output logic             warn_o,
    output logic             hit_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] WARN_AT = CNT_W'(WARN_CYCLES);
    localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(HALT_CYCLES - 1);
    localparam logic [CNT_W-1:0] HALT_AT = CNT_W'(HALT_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             advance;

    assign advance = count_en_i & fault_i & tick_i & (cnt_q != HALT_AT);

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            cnt_q <= '0;
        end else if (count_en_i) begin
            if (!fault_i) begin
                cnt_q <= '0;
            end else if (advance) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign warn_o  = (cnt_q >= WARN_AT);
    assign hit_o   = advance & (cnt_q == LAST_AT);
    assign count_o = cnt_q;

endmodule

// File: rtl/fsup_sequencer.sv
module fsup_sequencer
    import fsup_pkg::*;
(
    input  logic       clk_i,
    input  logic       clr_i,
    input  logic       tpin_gnd_i,
    input  logic       hit_i,
    output seq_state_t state_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_WAIT: if (!tpin_gnd_i) state_d = SEQ_RUN;
            SEQ_RUN:  if (hit_i)       state_d = SEQ_HALT;
            SEQ_HALT: state_d = SEQ_HALT;
            default:  state_d = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            state_q <= SEQ_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int WARN_CYCLES = 1,
    parameter int HALT_CYCLES = 15
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic ovp_i,
    input  logic ocp_i,
    input  logic arc_i,
    input  logic ign_fail_i,
    input  logic hsw_i,
    input  logic ext_req_i,
    input  logic loop_ok_i,
    input  logic tick_i,
    input  logic tpin_gnd_i,
    output logic flt_n_o,
    output logic halt_o,
    output logic run_o,
    output logic dim_ok_o,
    output logic sync_ok_o
);

    logic             clr;
    int_flags_t       flags;
    fault_view_t      view;
    seq_state_t       state;
    logic             warn;
    logic             hit;
    logic             running;
    logic [CNT_W-1:0] count;

    assign clr = rst_i | ~en_i;

    always_comb begin
        flags.ovp = ovp_i;
        flags.ocp = ocp_i;
        flags.arc = arc_i;
        flags.ign = ign_fail_i;
        flags.hsw = hsw_i;
    end

    fsup_fault_merge u_merge (
        .clk_i        (clk_i),
        .clr_i        (clr),
        .flags_i      (flags),
        .ext_req_i    (ext_req_i),
        .loop_ok_i    (loop_ok_i),
        .status_low_i (warn),
        .view_o       (view)
    );

    fsup_cycle_timer #(
        .CNT_W       (CNT_W),
        .WARN_CYCLES (WARN_CYCLES),
        .HALT_CYCLES (HALT_CYCLES)
    ) u_timer (
        .clk_i      (clk_i),
        .clr_i      (clr),
        .count_en_i (running),
        .fault_i    (view.any),
        .tick_i     (tick_i),
        .warn_o     (warn),
        .hit_o      (hit),
        .count_o    (count)
    );

    fsup_sequencer u_seq (
        .clk_i      (clk_i),
        .clr_i      (clr),
        .tpin_gnd_i (tpin_gnd_i),
        .hit_i      (hit),
        .state_o    (state)
    );

    assign running   = (state == SEQ_RUN);
    assign run_o     = running;
    assign halt_o    = (state == SEQ_HALT);
    assign flt_n_o   = ~warn;
    assign dim_ok_o  = running & ~view.int_any;
    assign sync_ok_o = running & ~view.int_any;

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic ovp_i,
    input logic ocp_i,
    input logic arc_i,
    input logic ign_fail_i,
    input logic hsw_i,
    input logic tick_i,
    input logic tpin_gnd_i,
    input logic flt_n_o,
    input logic halt_o,
    input logic run_o,
    input logic dim_ok_o,
    input logic sync_ok_o
);

    logic int_flag;
    assign int_flag = ovp_i | ocp_i | arc_i | ign_fail_i | hsw_i;

    assert_enable_clear_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!halt_o && flt_n_o && !run_o));

    assert_start_gate_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_o) |-> $past(!tpin_gnd_i));

    assert_int_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        int_flag |-> (!dim_ok_o && !sync_ok_o));

    assert_warn_on_tick_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(flt_n_o) |-> $past(tick_i));

    assert_halt_on_tick_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(halt_o) |-> $past(tick_i));

    assert_halt_latched_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_o && en_i) |=> halt_o);

    assert_halt_excl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_o |-> (!run_o && !flt_n_o));

endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .ovp_i      (ovp_i),
    .ocp_i      (ocp_i),
    .arc_i      (arc_i),
    .ign_fail_i (ign_fail_i),
    .hsw_i      (hsw_i),
    .tick_i     (tick_i),
    .tpin_gnd_i (tpin_gnd_i),
    .flt_n_o    (flt_n_o),
    .halt_o     (halt_o),
    .run_o      (run_o),
    .dim_ok_o   (dim_ok_o),
    .sync_ok_o  (sync_ok_o)
);

// File: tb/fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_supervisor_tb_top;

    logic clk = 1'b0;
    logic rst, en, ovp, ocp, arc, ign, hsw, ext, loop_ok, tick, tpin;
    logic flt_n, halt, run, dim_ok, sync_ok;
    int   vecs = 0;
    int   errs = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    fault_supervisor dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .ovp_i      (ovp),
        .ocp_i      (ocp),
        .arc_i      (arc),
        .ign_fail_i (ign),
        .hsw_i      (hsw),
        .ext_req_i  (ext),
        .loop_ok_i  (loop_ok),
        .tick_i     (tick),
        .tpin_gnd_i (tpin),
        .flt_n_o    (flt_n),
        .halt_o     (halt),
        .run_o      (run),
        .dim_ok_o   (dim_ok),
        .sync_ok_o  (sync_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
        end
    endtask

    task automatic quiet();
        ovp = 0; ocp = 0; arc = 0; ign = 0; hsw = 0;
        ext = 0; loop_ok = 0; tick = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst = 1'b1; en = 1'b1;
        step(2);
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset();
        quiet();
        tpin = 0; rst = 1'b1; en = 1'b1;
        step(2);
        chk("R1 flt_n in reset", flt_n, 1);
        chk("R1 halt in reset", halt, 0);
        chk("R1 run in reset", run, 0);
        chk("R1 dim in reset", dim_ok, 0);
        rst = 1'b0;
        step();
        chk("R2 run after reset", run, 1);
        chk("R3 dim follows run", dim_ok, 1);
    endtask

    task automatic t_start_block();
        tpin = 1'b1;
        do_reset();
        step(3);
        chk("R2 run blocked by tpin", run, 0);
        ovp = 1'b1;
        ticks(3);
        chk("R2 no count while waiting", flt_n, 1);
        ovp = 1'b0; tpin = 1'b0;
        step();
        chk("R2 run after tpin clear", run, 1);
    endtask

    task automatic t_int_gate();
        for (int i = 0; i < 5; i++) begin
            quiet();
            case (i)
                0: ovp = 1'b1;
                1: ocp = 1'b1;
                2: arc = 1'b1;
                3: ign = 1'b1;
                default: hsw = 1'b1;
            endcase
            #1;
            chk("R3 dim off on internal", dim_ok, 0);
            chk("R3 sync off on internal", sync_ok, 0);
        end
        quiet();
        #1;
        chk("R3 dim back on", dim_ok, 1);
        step();
    endtask

    task automatic t_warn_halt();
        ocp = 1'b1;
        ticks(1);
        chk("R7 warn after one period", flt_n, 0);
        ticks(13);
        chk("R8 no halt after 14", halt, 0);
        ticks(1);
        chk("R8 halt after 15", halt, 1);
        chk("R8 run off in halt", run, 0);
        ocp = 1'b0;
        step(2);
        chk("R8 halt latched", halt, 1);
        chk("R8 flt_n stays low", flt_n, 0);
        chk("R8 dim off in halt", dim_ok, 0);
        en = 1'b0;
        step();
        chk("R11 halt cleared", halt, 0);
        chk("R11 flt_n released", flt_n, 1);
        chk("R1 run off when disabled", run, 0);
        en = 1'b1;
        step();
        chk("R11 run restarts", run, 1);
        arc = 1'b1;
        ticks(14);
        chk("R11 counter cleared", halt, 0);
        arc = 1'b0;
        step();
    endtask

    task automatic t_clear();
        ticks(3);
        chk("R6 no count without fault", flt_n, 1);
        hsw = 1'b1;
        ticks(5);
        chk("R7 warn during fault", flt_n, 0);
        hsw = 1'b0;
        step();
        chk("R9 release on clear", flt_n, 1);
        hsw = 1'b1;
        ticks(14);
        chk("R9 full window again", halt, 0);
        chk("R6 counted 14", flt_n, 0);
        hsw = 1'b0;
        step();
        chk("R9 release again", flt_n, 1);
    endtask

    task automatic t_ext();
        ext = 1'b1; loop_ok = 1'b0;
        step();
        ticks(3);
        chk("R5 not sampled with loop open", flt_n, 1);
        loop_ok = 1'b1;
        step();
        chk("R4 dim kept on ext", dim_ok, 1);
        chk("R4 sync kept on ext", sync_ok, 1);
        ticks(1);
        chk("R5 ext counted", flt_n, 0);
        chk("R4 dim still on", dim_ok, 1);
        ext = 1'b0;
        step();
        chk("R10 ext change ignored", flt_n, 0);
        ticks(14);
        chk("R8 halt from ext fault", halt, 1);
        chk("R8 dim off in halt", dim_ok, 0);
        en = 1'b0; loop_ok = 1'b0;
        step();
        en = 1'b1;
        step();
    endtask

    task automatic t_ignore();
        ign = 1'b1;
        ticks(1);
        chk("R7 warn from ignition", flt_n, 0);
        ign = 1'b0; ext = 1'b1; loop_ok = 1'b1;
        step();
        chk("R10 ext not captured while low", flt_n, 1);
        step();
        ticks(1);
        chk("R5 ext captured after release", flt_n, 0);
        chk("R4 dim on for ext", dim_ok, 1);
        ext = 1'b0; loop_ok = 1'b0;
        en = 1'b0;
        step();
        en = 1'b1;
        step();
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; tpin = 1'b0;
        quiet();
        t_reset();
        t_start_block();
        t_int_gate();
        t_warn_halt();
        t_clear();
        t_ext();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            vecs++;
            errs++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule